// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block takes fixed-length parallel words over a valid/ready handshake and sends each one out most significant bit first on a single serial data line. It generates its own frame sync. All timing is in bit slots. A bit slot starts at a system clock edge where the bit-clock enable is high. The serial data and frame sync outputs change only at those edges and hold their values in between.

A mode input selects where the frame sync falls relative to the word. In early framing the sync is a one-slot pulse placed in the slot just before the first data bit. When words run back to back, that pulse therefore lands on the last bit of the previous word. In late framing the sync rises in the same slot as the first data bit and stays high for every bit of the word. The mode is captured together with each word, so a word is framed according to the mode present when it was accepted. The handshake accepts the next word early enough that consecutive words leave no idle slot between them. With nothing pending, the line rests low and the sync stays low.

Top module: `framed_serial_tx`

## Requirements
- R1: After reset, serial data and frame sync are low, and `in_ready` is high in every cycle where `bit_en` is high, until the first word is accepted.
- R2: Each accepted word is sent as exactly WORD_BITS bits, most significant first, one bit per enabled slot. Outputs hold their value in cycles where `bit_en` is low.
- R3: With `late_mode` = 0 at acceptance (early framing), frame sync is high for exactly one slot, which is the acceptance slot. The first data bit follows in the next slot.
- R4: In early framing with a word pending when the current word ends, the next frame sync is driven in the same slot as the current word's last bit.
- R5: With `late_mode` = 1 at acceptance (late framing), the first data bit and frame sync both appear in the acceptance slot, and frame sync stays high for all WORD_BITS slots of the word.
- R6: A word transfers only in a cycle with `in_valid`, `in_ready` and `bit_en` all high. `in_ready` is low whenever `bit_en` is low. `in_ready` is high when the shifter is idle, and also during the last bit of a word if the offered word uses early framing. A word offered as soon as it can be accepted starts its first bit in the slot right after the previous word's last bit.
- R7: In a slot with no word bit to send, serial data is 0 and frame sync is 0 unless an early-framing word is accepted in that slot.
- R8: Changing `late_mode` while a word is being sent has no effect on that word's bits or frame sync.
- R9: `in_data` is ignored in cycles without a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable; one serial slot per high cycle |
| late_mode | input | 1 | Framing mode for the offered word: 0 early, 1 late |
| in_data | input | WORD_BITS | Parallel word to send |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block takes the offered word at this edge |
| sdo | output | 1 | Serial data, registered |
| fsync | output | 1 | Frame sync, registered |

## Verification
`in_ready` is combinational, so the bench reads it one time unit after it changes the inputs. It records the index of the enabled edge at which each handshake completes. Both outputs are registered, so the value that an enabled edge produces is read at the next falling clock edge and stored against that slot index. For a word accepted at slot t, early framing predicts the sync at t and the bits at t+1 through t+WORD_BITS. Late framing predicts the sync and the bits at t through t+WORD_BITS-1. Every recorded slot is compared with these predictions, and the comparison is repeated with the enable high every cycle and with the enable high one cycle in three.

// File: rtl/fst_pkg.sv
package fst_pkg;
  // Framing choice captured with each word
  typedef enum logic {
    FRAME_EARLY = 1'b0,
    FRAME_LATE  = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/fst_accept.sv
// Decides when the next word may be taken from the handshake.
module fst_accept #(
  parameter int CNT_W = 5
) (
  input  logic             bit_en,
  input  logic             in_valid,
  input  logic             late_mode,
  input  logic [CNT_W-1:0] rem,
  output logic             in_ready,
  output logic             take
);
  logic room;

  // Early words load one slot ahead (their sync precedes the data),
  // late words load exactly when the previous word has drained.
  always_comb begin
    if (late_mode) room = (rem == '0);
    else           room = (rem <= CNT_W'(1));
    in_ready = bit_en & room;
    take     = in_ready & in_valid;
  end
endmodule

// File: rtl/fst_shifter.sv
// Holds the word being sent and drives the serial data bit.
module fst_shifter #(
  parameter int WORD_BITS = 16,
  parameter int CNT_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic                 take,
  input  logic                 late_mode,
  input  logic [WORD_BITS-1:0] in_data,
  output logic                 sdo,
  output logic [CNT_W-1:0]     rem
);
  localparam int              MSB      = WORD_BITS - 1;
  localparam logic [CNT_W-1:0] REM_FULL = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] REM_LESS = CNT_W'(WORD_BITS - 1);

  logic [WORD_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      rem   <= '0;
      sdo   <= 1'b0;
    end else if (take) begin
      if (late_mode) begin
        // first bit leaves in the acceptance slot
        sdo   <= in_data[MSB];
        shreg <= {in_data[MSB-1:0], 1'b0};
        rem   <= REM_LESS;
      end else begin
        // finish the old word (if any) while the sync slot runs
        sdo   <= (rem != '0) ? shreg[MSB] : 1'b0;
        shreg <= in_data;
        rem   <= REM_FULL;
      end
    end else if (bit_en) begin
      if (rem != '0) begin
        sdo   <= shreg[MSB];
        shreg <= {shreg[MSB-1:0], 1'b0};
        rem   <= rem - CNT_W'(1);
      end else begin
        sdo   <= 1'b0;
      end
    end
  end

  // R2: nothing moves between enabled slots
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(sdo) && $stable(rem)));

  // R2: the bit counter never exceeds one word
  a_r2_rem_range: assert property (@(posedge clk) disable iff (rst)
    rem <= REM_FULL);
endmodule

// File: rtl/fst_framer.sv
// Generates the frame sync and remembers the mode of the word in flight.
module fst_framer
  import fst_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bit_en,
  input  logic        take,
  input  logic        late_mode,
  input  logic        busy,
  output logic        fsync,
  output frame_mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fsync  <= 1'b0;
      mode_q <= FRAME_EARLY;
    end else if (take) begin
      fsync  <= 1'b1;
      mode_q <= late_mode ? FRAME_LATE : FRAME_EARLY;
    end else if (bit_en) begin
      // late framing keeps the sync up while bits remain
      fsync  <= (mode_q == FRAME_LATE) && busy;
    end
  end

  // R8: mode is only captured at a word boundary
  a_r8_mode_held: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(mode_q));
endmodule

// File: rtl/framed_serial_tx.sv
module framed_serial_tx
  import fst_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic                 late_mode,
  input  logic [WORD_BITS-1:0] in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 sdo,
  output logic                 fsync
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);

  logic             take;
  logic [CNT_W-1:0] rem;
  frame_mode_e      mode_q;

  fst_accept #(.CNT_W(CNT_W)) u_accept (
    .bit_en   (bit_en),
    .in_valid (in_valid),
    .late_mode(late_mode),
    .rem      (rem),
    .in_ready (in_ready),
    .take     (take)
  );

  fst_shifter #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_shifter (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .take     (take),
    .late_mode(late_mode),
    .in_data  (in_data),
    .sdo      (sdo),
    .rem      (rem)
  );

  fst_framer u_framer (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .take     (take),
    .late_mode(late_mode),
    .busy     (rem != '0),
    .fsync    (fsync),
    .mode_q   (mode_q)
  );

  // R7: an idle slot with no new word leaves both lines low
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !take && rem == '0) |=> (!sdo && !fsync));

  // R3: an early sync lasts one slot
  a_r3_early_single: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !take && fsync && mode_q == FRAME_EARLY) |=> !fsync);

  // R5: a late sync stays up while bits remain
  a_r5_late_hold: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !take && mode_q == FRAME_LATE && rem != '0) |=> fsync);

  // R4: back-to-back early word raises sync on the last bit
  a_r4_early_overlap: assert property (@(posedge clk) disable iff (rst)
    (take && !late_mode && rem == CNT_W'(1)) |=> (fsync && rem == CNT_W'(WORD_BITS)));
endmodule

// File: tb/test_framed_serial_tx.sv
`timescale 1ns/1ps
module test_framed_serial_tx;
  localparam int W    = 8;
  localparam int NW   = 20;
  localparam int MAXT = 1024;

  logic         clk = 1'b0;
  logic         rst;
  logic         bit_en;
  logic         late_mode;
  logic [W-1:0] in_data;
  logic         in_valid;
  logic         in_ready;
  logic         sdo;
  logic         fsync;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  framed_serial_tx #(.WORD_BITS(W)) i_framed_serial_tx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .late_mode(late_mode),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .sdo(sdo), .fsync(fsync)
  );

  logic [W-1:0] dat  [NW];
  bit           mode [NW];
  int           gap  [NW];
  int           acc  [NW];
  bit got_sd [MAXT];
  bit got_fs [MAXT];
  bit exp_sd [MAXT];
  bit exp_fs [MAXT];
  int sd_req [MAXT];
  int fs_req [MAXT];
  int tick;

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic int first_bit(input int n);
    return acc[n] + (mode[n] ? 0 : 1);
  endfunction

  task automatic run_phase(input int div);
    int  idx       = 0;
    int  gap_left  = gap[0];
    int  tail      = 0;
    int  cyc       = 0;
    bit  prev_en   = 1'b0;
    tick = 0;
    // reset (R1)
    rst = 1'b1; bit_en = 1'b0; in_valid = 1'b0; late_mode = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    bit_en = 1'b1;
    #1;
    check(sdo == 1'b0 && fsync == 1'b0, "R1", "outputs after reset", {sdo, fsync}, 0);
    check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    bit_en = 1'b0;
    while (idx < NW || tail < W + 4) begin
      @(negedge clk);
      cycles++;
      if (cycles > 20000) begin
        check(1'b0, "R6", "phase watchdog", idx, NW);
        return;
      end
      if (prev_en) begin
        got_sd[tick] = sdo;
        got_fs[tick] = fsync;
        tick++;
        if (idx == NW) tail++;
      end
      bit_en = ((cyc % div) == 0);
      cyc++;
      if (idx < NW && gap_left == 0) begin
        in_valid  = 1'b1;
        in_data   = dat[idx];
        late_mode = mode[idx];
      end else begin
        // R8, R9: mode and data wander while nothing is offered
        in_valid  = 1'b0;
        in_data   = ~in_data ^ W'(cyc);
        late_mode = cyc[1];
        if (bit_en && gap_left > 0) gap_left--;
      end
      #1;
      if (!bit_en) check(in_ready == 1'b0, "R6", "ready without enable", in_ready, 0);
      if (in_valid && in_ready) begin
        acc[idx] = tick;
        idx++;
        if (idx < NW) gap_left = gap[idx];
      end
      prev_en = bit_en;
    end
  endtask

  task automatic verify_phase(input int div);
    for (int t = 0; t < MAXT; t++) begin
      exp_sd[t] = 1'b0; exp_fs[t] = 1'b0; sd_req[t] = 7; fs_req[t] = 7;
    end
    for (int n = 0; n < NW; n++) begin
      int fb = first_bit(n);
      for (int k = 0; k < W; k++) begin
        exp_sd[fb + k] = dat[n][W-1-k];
        sd_req[fb + k] = 2;
      end
      if (mode[n]) begin
        for (int k = 0; k < W; k++) begin exp_fs[fb + k] = 1'b1; fs_req[fb + k] = 5; end
      end else begin
        exp_fs[acc[n]] = 1'b1;
        fs_req[acc[n]] = (sd_req[acc[n]] == 2) ? 4 : 3;
      end
    end
    // slot-by-slot comparison (R2 R3 R4 R5 R7)
    for (int t = 0; t < tick; t++) begin
      check(got_sd[t] == exp_sd[t], $sformatf("R%0d", sd_req[t]),
            $sformatf("div%0d sdo slot %0d", div, t), got_sd[t], exp_sd[t]);
      check(got_fs[t] == exp_fs[t], $sformatf("R%0d", fs_req[t]),
            $sformatf("div%0d fsync slot %0d", div, t), got_fs[t], exp_fs[t]);
    end
    for (int n = 0; n < NW; n++) begin
      int fb = first_bit(n);
      logic [W-1:0] word = '0;
      int syncs = 0;
      for (int k = 0; k < W; k++) word = {word[W-2:0], got_sd[fb + k]};
      // R9: the decoded word equals the one handed over
      check(word == dat[n], "R9", $sformatf("div%0d word %0d", div, n), word, dat[n]);
      // R8: sync shape inside the word follows the captured mode
      for (int k = 0; k < W - 1; k++) syncs += got_fs[fb + k];
      check(syncs == (mode[n] ? W - 1 : 0), "R8",
            $sformatf("div%0d word %0d sync count", div, n), syncs, mode[n] ? W - 1 : 0);
      if (n > 0 && gap[n] == 0) begin
        // R6: no idle slot between back-to-back words
        check(fb == first_bit(n - 1) + W, "R6",
              $sformatf("div%0d word %0d start slot", div, n), fb, first_bit(n - 1) + W);
        if (!mode[n])
          // R4: early sync coincides with last bit of previous word
          check(got_fs[first_bit(n - 1) + W - 1] == 1'b1, "R4",
                $sformatf("div%0d word %0d overlap sync", div, n),
                got_fs[first_bit(n - 1) + W - 1], 1);
      end
    end
  endtask

  initial begin
    for (int n = 0; n < NW; n++) begin
      dat[n]  = W'(n * 53 + 29);
      mode[n] = (n % 3 == 1) || (n % 5 == 0);
      gap[n]  = (n % 4 == 3) ? 10 : ((n % 7 == 5) ? 2 : 0);
    end
    dat[0] = 8'h80; dat[1] = 8'h01; dat[2] = 8'hFF; dat[3] = 8'h00;
    gap[0] = 3;
    run_phase(1);
    verify_phase(1);
    run_phase(3);
    verify_phase(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule